// File: doc/BRIEF.md
# Masked-Write GPIO Controller with Per-Pin Interrupt Sense

This block controls 32 general-purpose pins from a word-wide register bus. Direction is changed with separate set and clear registers, so software never has to read-modify-write the direction state. Output values live in a low-half and a high-half register. Each write to either half carries its own per-bit write mask in the upper 16 bits of the data word. The current pin levels can be read back after they pass through a two-flop synchroniser.

Every pin has a 4-bit sense code that selects one of five detection kinds: rising edge, falling edge, both edges, high level or low level. Any other code value turns detection off for that pin. The codes are packed eight to a register, in a window that starts at byte offset 0x40. A per-pin acceptance gate must be open for a detection to latch into the pending bit. A per-pin enable, which software sets and clears through separate registers, decides whether a pending bit reaches the interrupt lines. Pins 0–15 drive the low interrupt line and pins 16–31 drive the high line.

Bus writes use `reg_we`, `reg_addr` and `reg_wdata` and take effect at the rising clock edge. Reads are combinational from `reg_addr`. Register byte offsets are:

| Offset | Purpose |
|---|---|
| 0x00 | direction set |
| 0x04 | direction clear |
| 0x08 | output, low half |
| 0x0C | output, high half |
| 0x10 | input levels |
| 0x14 | acceptance gate |
| 0x18 | enable set |
| 0x1C | enable clear |
| 0x20 | raw pending |
| 0x24 | masked pending |
| 0x28 | pending clear |
| 0x40–0x4C | sense codes |

Top module: `gpio_sense_ctl`

## Requirements
- R1: A write to offset 0x00 sets pin_oe for each data bit at 1. A write to 0x04 clears pin_oe for each data bit at 1. Data bits at 0 leave direction unchanged. A read of either offset returns the current pin_oe.
- R2: A write to 0x08 (pins 0–15) or 0x0C (pins 16–31) changes output bit i of that half to data bit i only when mask bit 16+i is 1. Reads return the half in bits 15:0 and zeros in bits 31:16.
- R3: A read of 0x10 returns the pin levels as they were two clock edges earlier, through a two-flop synchroniser.
- R4: The sense code for pin n sits in the register at 0x40 + 4*(n/8), bits (n mod 8)*4 +: 4. These registers read back as they were written.
- R5: Code 0x8 latches pending on a synchronised 0→1 transition, 0x9 on a 1→0 transition, and 0xC on either transition.
- R6: Code 0xA latches pending while the synchronised level is 1, and 0xB while it is 0. A clear issued while the condition holds leaves the bit set.
- R7: Any sense code other than 0x8–0xC never sets pending, whatever the pin does.
- R8: A write to 0x18 sets enable bits for data bits at 1, and a write to 0x1C clears them. 0x20 returns raw pending. 0x24 returns pending AND enable.
- R9: A pin whose bit in the acceptance register (0x14, read/write) is 0 never gets a new pending bit.
- R10: Writing 1 to a bit of 0x28 clears that pending bit, unless a detection for that pin occurs in the same cycle. Writing 0 has no effect.
- R11: irq_lo is the OR of masked pending bits 15:0, and irq_hi is the OR of bits 31:16.
- R12: After synchronous reset, all direction, output, enable, acceptance, sense and pending state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| pin_in | input | 32 | Pin levels from pads |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output value |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
Several pins are given different sense codes at the same time: rising, falling, both, high, low and one invalid code. Pins are then toggled one at a time, so a wrong field position or a mixed-up code shows up as pending on the wrong pin. Level pins are cleared while their condition holds and again after it ends, which separates level latching from edge latching. The gate is closed before an edge arrives, and the enable is switched off with pending still set, so raw status, masked status and the interrupt lines can be told apart. Masked output writes use sparse masks on both halves, so a mask bit taken from the wrong half or an unmasked bit that changes is caught.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_DIR_SET = 8'h00;
    localparam logic [ADDR_W-1:0] A_DIR_CLR = 8'h04;
    localparam logic [ADDR_W-1:0] A_OUT_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] A_OUT_HI  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_PIN_IN  = 8'h10;
    localparam logic [ADDR_W-1:0] A_ACCEPT  = 8'h14;
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 8'h18;
    localparam logic [ADDR_W-1:0] A_IRQ_DIS = 8'h1C;
    localparam logic [ADDR_W-1:0] A_RAW     = 8'h20;
    localparam logic [ADDR_W-1:0] A_MASKED  = 8'h24;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 8'h28;
    localparam logic [ADDR_W-1:0] A_SENSE0  = 8'h40;

    localparam int unsigned CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        SNS_RISE = 4'h8,
        SNS_FALL = 4'h9,
        SNS_HIGH = 4'hA,
        SNS_LOW  = 4'hB,
        SNS_BOTH = 4'hC
    } sense_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_samp_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic sense_hit(input logic [CODE_W-1:0] code,
                                       input pin_samp_t s);
        logic r;
        case (code)
            SNS_RISE: r = s.cur & ~s.prev;
            SNS_FALL: r = ~s.cur & s.prev;
            SNS_HIGH: r = s.cur;
            SNS_LOW:  r = ~s.cur;
            SNS_BOTH: r = s.cur ^ s.prev;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic is_wr(input bus_wr_t b, input logic [ADDR_W-1:0] a);
        return b.we && (b.addr == a);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= d;
            cur    <= meta_q;
            prev   <= cur;
        end
    end
endmodule

// File: rtl/gpio_sense_detect.sv
module gpio_sense_detect
    import gpio_sense_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic [NPINS*CODE_W-1:0] codes,
    input  logic [NPINS-1:0]        cur,
    input  logic [NPINS-1:0]        prev,
    input  logic [NPINS-1:0]        accept,
    output logic [NPINS-1:0]        hit
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_samp_t samp;
        assign samp.cur  = cur[i];
        assign samp.prev = prev[i];
        assign hit[i] = accept[i] & sense_hit(codes[i*CODE_W +: CODE_W], samp);
    end
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_sense_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  bus_wr_t                 bus,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic [NPINS-1:0]        pin_lvl,
    input  logic [NPINS-1:0]        hit,
    output logic [NPINS*CODE_W-1:0] codes,
    output logic [NPINS-1:0]        accept_q,
    output logic [NPINS-1:0]        oe_q,
    output logic [NPINS-1:0]        out_q,
    output logic [NPINS-1:0]        status
);
    localparam int unsigned HALF   = NPINS / 2;
    localparam int unsigned PER_RG = DATA_W / CODE_W;
    localparam int unsigned NSNS   = NPINS / PER_RG;

    logic [NPINS-1:0]  en_q;
    logic [NPINS-1:0]  pend_q;
    logic [DATA_W-1:0] sense_q [NSNS];
    logic [NPINS-1:0]  clr_mask;
    logic [HALF-1:0]   wmask;
    logic [HALF-1:0]   wval;

    assign wmask    = bus.data[HALF +: HALF];
    assign wval     = bus.data[HALF-1:0];
    assign clr_mask = is_wr(bus, A_CLEAR) ? bus.data[NPINS-1:0] : '0;
    assign status   = pend_q & en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q     <= '0;
            out_q    <= '0;
            en_q     <= '0;
            accept_q <= '0;
            pend_q   <= '0;
        end else begin
            if (is_wr(bus, A_DIR_SET)) oe_q <= oe_q | bus.data[NPINS-1:0];
            if (is_wr(bus, A_DIR_CLR)) oe_q <= oe_q & ~bus.data[NPINS-1:0];
            if (is_wr(bus, A_OUT_LO))
                out_q[HALF-1:0] <= (out_q[HALF-1:0] & ~wmask) | (wval & wmask);
            if (is_wr(bus, A_OUT_HI))
                out_q[NPINS-1:HALF] <= (out_q[NPINS-1:HALF] & ~wmask) | (wval & wmask);
            if (is_wr(bus, A_IRQ_EN))  en_q <= en_q | bus.data[NPINS-1:0];
            if (is_wr(bus, A_IRQ_DIS)) en_q <= en_q & ~bus.data[NPINS-1:0];
            if (is_wr(bus, A_ACCEPT))  accept_q <= bus.data[NPINS-1:0];
            pend_q <= (pend_q & ~clr_mask) | hit;
        end
    end

    for (genvar k = 0; k < NSNS; k++) begin : g_sense
        localparam logic [ADDR_W-1:0] KADDR = A_SENSE0 + ADDR_W'(k * 4);
        always_ff @(posedge clk) begin
            if (rst)                  sense_q[k] <= '0;
            else if (is_wr(bus, KADDR)) sense_q[k] <= bus.data;
        end
        assign codes[k*DATA_W +: DATA_W] = sense_q[k];
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_DIR_SET, A_DIR_CLR: rd_data[NPINS-1:0] = oe_q;
            A_OUT_LO:             rd_data[HALF-1:0]  = out_q[HALF-1:0];
            A_OUT_HI:             rd_data[HALF-1:0]  = out_q[NPINS-1:HALF];
            A_PIN_IN:             rd_data[NPINS-1:0] = pin_lvl;
            A_ACCEPT:             rd_data[NPINS-1:0] = accept_q;
            A_IRQ_EN, A_IRQ_DIS:  rd_data[NPINS-1:0] = en_q;
            A_RAW:                rd_data[NPINS-1:0] = pend_q;
            A_MASKED:             rd_data[NPINS-1:0] = status;
            default: begin
                for (int k = 0; k < NSNS; k++)
                    if (rd_addr == A_SENSE0 + ADDR_W'(k * 4)) rd_data = sense_q[k];
            end
        endcase
    end

    // R1: bits written to the set register are outputs on the next cycle
    a_r1_dir_set: assert property (@(posedge clk) disable iff (rst)
        is_wr(bus, A_DIR_SET) |=> ((oe_q & $past(bus.data[NPINS-1:0])) == $past(bus.data[NPINS-1:0])));

    // R1: bits written to the clear register are inputs on the next cycle
    a_r1_dir_clr: assert property (@(posedge clk) disable iff (rst)
        is_wr(bus, A_DIR_CLR) |=> ((oe_q & $past(bus.data[NPINS-1:0])) == '0));

    // R2: unmasked low-half bits hold their value
    a_r2_out_mask: assert property (@(posedge clk) disable iff (rst)
        is_wr(bus, A_OUT_LO) |=> ((out_q[HALF-1:0] & ~$past(wmask)) == ($past(out_q[HALF-1:0]) & ~$past(wmask))));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        // R9: a closed gate never creates a new pending bit
        a_r9_gate_closed: assert property (@(posedge clk) disable iff (rst)
            (!accept_q[i] && !pend_q[i]) |=> !pend_q[i]);
        // R10: a clear with no detection in the same cycle empties the bit
        a_r10_clear: assert property (@(posedge clk) disable iff (rst)
            (is_wr(bus, A_CLEAR) && bus.data[i] && !hit[i]) |=> !pend_q[i]);
    end
endmodule

// File: rtl/gpio_sense_ctl.sv
module gpio_sense_ctl
    import gpio_sense_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_out,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int unsigned HALF = NPINS / 2;

    bus_wr_t                 bus;
    logic [NPINS-1:0]        lvl_cur;
    logic [NPINS-1:0]        lvl_prev;
    logic [NPINS-1:0]        hit;
    logic [NPINS-1:0]        accept;
    logic [NPINS-1:0]        status;
    logic [NPINS*CODE_W-1:0] codes;

    assign bus.we   = reg_we;
    assign bus.addr = reg_addr;
    assign bus.data = reg_wdata;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    (pin_in),
        .cur  (lvl_cur),
        .prev (lvl_prev)
    );

    gpio_sense_detect #(.NPINS(NPINS)) u_detect (
        .codes  (codes),
        .cur    (lvl_cur),
        .prev   (lvl_prev),
        .accept (accept),
        .hit    (hit)
    );

    gpio_reg_file #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .rd_addr  (reg_addr),
        .rd_data  (reg_rdata),
        .pin_lvl  (lvl_cur),
        .hit      (hit),
        .codes    (codes),
        .accept_q (accept),
        .oe_q     (pin_oe),
        .out_q    (pin_out),
        .status   (status)
    );

    assign irq_lo = |status[HALF-1:0];
    assign irq_hi = |status[NPINS-1:HALF];
endmodule

// File: tb/gpio_sense_ctl_bench.sv
`timescale 1ns/1ps
module gpio_sense_ctl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = 32'h0;
    logic [31:0] pin_oe, pin_out;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_oe, m_out, m_en, m_acc, m_pend, m_s1, m_s2, m_s3;
    logic [31:0] m_sense [4];

    always #10 clk = ~clk;

    gpio_sense_ctl u_gpio_sense_ctl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    function automatic bit m_hit(int n);
        logic [3:0] c;
        c = m_sense[n / 8][(n % 8) * 4 +: 4];
        if (!m_acc[n]) return 1'b0;
        case (c)
            4'h8: return m_s2[n] && !m_s3[n];
            4'h9: return !m_s2[n] && m_s3[n];
            4'hA: return m_s2[n];
            4'hB: return !m_s2[n];
            4'hC: return m_s2[n] != m_s3[n];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_oe = 0; m_out = 0; m_en = 0; m_acc = 0; m_pend = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            for (int k = 0; k < 4; k++) m_sense[k] = 0;
        end else begin
            logic [31:0] h, clr;
            h = 0;
            for (int n = 0; n < 32; n++) h[n] = m_hit(n);
            clr = 0;
            if (reg_we) begin
                case (reg_addr)
                    8'h00: m_oe = m_oe | reg_wdata;
                    8'h04: m_oe = m_oe & ~reg_wdata;
                    8'h08: for (int b = 0; b < 16; b++) if (reg_wdata[16+b]) m_out[b] = reg_wdata[b];
                    8'h0C: for (int b = 0; b < 16; b++) if (reg_wdata[16+b]) m_out[16+b] = reg_wdata[b];
                    8'h14: m_acc = reg_wdata;
                    8'h18: m_en = m_en | reg_wdata;
                    8'h1C: m_en = m_en & ~reg_wdata;
                    8'h28: clr = reg_wdata;
                    8'h40, 8'h44, 8'h48, 8'h4C: m_sense[(reg_addr - 8'h40) / 4] = reg_wdata;
                    default: ;
                endcase
            end
            m_pend = (m_pend & ~clr) | h;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00, 8'h04: return m_oe;
            8'h08: return {16'h0, m_out[15:0]};
            8'h0C: return {16'h0, m_out[31:16]};
            8'h10: return m_s2;
            8'h14: return m_acc;
            8'h18, 8'h1C: return m_en;
            8'h20: return m_pend;
            8'h24: return m_pend & m_en;
            8'h40, 8'h44, 8'h48, 8'h4C: return m_sense[(a - 8'h40) / 4];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // every-cycle comparison of the pin and interrupt outputs
    always @(negedge clk) begin
        #3;
        if (!rst && !done) begin
            check("R1 pin_oe", pin_oe, m_oe);
            check("R2 pin_out", pin_out, m_out);
            check("R11 irq lines", {30'h0, irq_hi, irq_lo},
                  {30'h0, |(m_pend[31:16] & m_en[31:16]), |(m_pend[15:0] & m_en[15:0])});
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, string tag);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1;
        check(tag, reg_rdata, m_read(a));
    endtask

    task automatic pins(logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        rd(8'h00, "R12 oe reset");
        rd(8'h08, "R12 out reset");
        rd(8'h14, "R12 accept reset");
        rd(8'h18, "R12 enable reset");
        rd(8'h20, "R12 pending reset");
        rd(8'h4C, "R12 sense reset");
        check("R12 oe literal", pin_oe, 32'h0);

        // R1: direction set/clear, zero bits no effect
        wr(8'h00, 32'h8000_00F0);
        rd(8'h00, "R1 after set");
        wr(8'h04, 32'h0000_0030);
        rd(8'h04, "R1 after clear");
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        rd(8'h00, "R1 zero writes");
        check("R1 literal", pin_oe, 32'h8000_00C0);

        // R2: masked writes on both halves
        wr(8'h08, 32'h00FF_00AA);
        rd(8'h08, "R2 low half");
        wr(8'h08, 32'h0F00_FFFF);
        rd(8'h08, "R2 low sparse mask");
        wr(8'h0C, 32'h8001_FFFF);
        rd(8'h0C, "R2 high half");
        wr(8'h0C, 32'h0000_0000);
        check("R2 literal", pin_out, 32'h8001_0FAA);

        // R3: synchronised input readback with latency
        @(negedge clk); pin_in = 32'h1234_5678;
        rd(8'h10, "R3 one edge later");
        rd(8'h10, "R3 two edges later");
        idle(2);
        rd(8'h10, "R3 settled");
        pins(32'h0000_0000);

        // R4: sense fields; pin0 rise, pin5 both, pin6 invalid 0x3,
        // pin9 fall, pin18 high, pin31 low
        wr(8'h40, 32'h03C0_0008);
        wr(8'h44, 32'h0000_0090);
        wr(8'h48, 32'h0000_0A00);
        wr(8'h4C, 32'hB000_0000);
        rd(8'h40, "R4 sense0");
        rd(8'h44, "R4 sense1");
        rd(8'h48, "R4 sense2");
        rd(8'h4C, "R4 sense3");
        wr(8'h18, 32'h8004_0261);
        wr(8'h14, 32'hFFFF_FFFF);
        idle(2);
        rd(8'h20, "R6 low level latched");
        rd(8'h24, "R8 masked status");

        // R5: edges
        pins(32'h0000_0201);
        rd(8'h20, "R5 rise pin0");
        wr(8'h28, 32'h0000_0001);
        rd(8'h20, "R10 clear pin0");
        pins(32'h0000_0200);
        rd(8'h20, "R5 pin0 fall ignored");
        pins(32'h0000_0000);
        rd(8'h20, "R5 fall pin9");
        pins(32'h0000_0020);
        rd(8'h20, "R5 both rise pin5");
        wr(8'h28, 32'h0000_0200);
        pins(32'h0000_0000);
        rd(8'h20, "R5 both fall pin5");
        wr(8'h28, 32'h0000_0221);
        rd(8'h20, "R10 multi clear");

        // R7: invalid code ignores activity
        pins(32'h0000_0040);
        pins(32'h0000_0000);
        rd(8'h20, "R7 pin6 no pending");

        // R6: level held through clear
        pins(32'h0004_0000);
        wr(8'h28, 32'h0004_0000);
        rd(8'h20, "R6 high persists");
        pins(32'h8000_0000);
        wr(8'h28, 32'h0004_0000);
        rd(8'h20, "R6 high cleared");
        wr(8'h28, 32'h0000_0000);
        rd(8'h20, "R10 zero clear no effect");

        // R9: closed gate
        wr(8'h14, 32'hFFFF_FFFE);
        pins(32'h8000_0001);
        rd(8'h20, "R9 gate closed pin0");
        rd(8'h14, "R9 accept readback");
        wr(8'h14, 32'hFFFF_FFFF);
        pins(32'h8000_0000);
        pins(32'h8000_0001);
        rd(8'h24, "R8 masked pin0");

        // R8: disable keeps raw, removes masked
        wr(8'h1C, 32'h0000_0001);
        rd(8'h20, "R8 raw after disable");
        rd(8'h24, "R8 masked after disable");
        wr(8'h18, 32'h0000_0001);
        rd(8'h1C, "R8 enable readback");
        idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule